// File: doc/BRIEF.md
# Autobaud Debug Serial Link

This block is the serial front end of an on-chip debug port. It connects a host computer's asynchronous serial line to a debug command engine that sits inside the chip. The block never uses a programmed baud divisor. After reset it stays unlocked until the host sends the sync character 0x80. The block counts how long the line stays low during that character. The start bit and data bits 0 to 6 are all low, so the low time covers eight bit times. The measured count divided by eight becomes the bit period, and that one period is then used to receive and to send 8N1 bytes.

The receive pin passes through a chain of flip-flops clocked by the system clock before any state machine sees it. Received bytes go to the command engine through a valid/ready byte port. The engine returns response bytes through a second valid/ready port, and the block shifts them out on the transmit line. A stop bit sampled low is reported as a framing error. If the line is held low for longer than ten bit times, the block treats it as a break: it forgets the learned rate and waits for a new sync character.

The block works with one bit period of four or more system clocks. At 115200 bit/s and a system clock of about 16.67 MHz, one bit lasts about 145 clocks, which is well inside that range.

Top module: `dbgUart`

## Requirements
- R1: After a synchronous reset the block is in this state: `txLine` is 1, `rxValid` is 0, `txReady` is 0, `frameErr` is 0 and `baudLocked` is 0.
- R2: While `baudLocked` is 0, the block delivers no received byte on `rxValid` and keeps `txReady` at 0.
- R3: A low run on the line is ignored for rate learning if its length divided by eight is below `MIN_PERIOD` clocks. The block then stays unlocked and waits for the next low run.
- R4: A 0x80 character whose low time is L clocks sets `baudLocked` to 1. It also sets the bit period to floor(L/8) clocks, and every later transmitted bit lasts exactly that many clocks. The sync character itself is not delivered as a byte.
- R5: A received frame is decoded as follows: a low start bit, eight data bits with the LSB first, and a high stop bit. The block samples each bit near its middle. The byte then appears on `rxData` with `rxValid` set to 1. `rxValid` and `rxData` stay unchanged until a cycle in which `rxReady` is 1.
- R6: If the stop bit is sampled low, `frameErr` is 1 for exactly one clock and no byte is delivered.
- R7: If the line is held low for more than ten bit periods, `baudLocked` returns to 0. The next 0x80 character then sets a new bit period.
- R8: A byte accepted while `txValid` and `txReady` are both 1 is sent as 10 bits on `txLine`: a 0 start bit, the data LSB first, and a 1 stop bit. `txReady` is 0 from the clock after acceptance until the stop bit has finished, and `txLine` is 1 whenever `txReady` is 1.
- R9: A low pulse on the line that is shorter than half a bit period is not taken as a start bit. It delivers no byte and raises no framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| rxPin | input | 1 | Asynchronous serial input from the host |
| txLine | output | 1 | Serial output to the host; idles high |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | `rxData` holds a byte that has not been taken yet |
| rxReady | input | 1 | The command engine takes the byte this cycle |
| txData | input | 8 | Response byte to send |
| txValid | input | 1 | `txData` is offered for sending |
| txReady | output | 1 | The transmitter is locked and idle and can take a byte |
| frameErr | output | 1 | One-clock pulse when a stop bit is sampled low |
| baudLocked | output | 1 | A bit period has been learned and is in use |

## Verification
The assertions check the handshake rules on every cycle:
- a pending received byte stays stable while `rxReady` is 0;
- the transmitter drops `txReady` after it accepts a byte, and the line is high whenever `txReady` is 1;
- `frameErr` is a single-cycle pulse;
- no byte appears and the transmitter never offers to accept while the block is unlocked.

The rest can only be shown by the bench's scenarios:
- that the learned bit period equals one eighth of the sync character's low time, which the bench shows at two different rates;
- that bits are taken LSB first at mid-bit;
- that a bad stop bit raises `frameErr` and delivers nothing;
- that a glitch is rejected;
- that a long low line unlocks the block so that the sync character can set a new rate.

// File: rtl/dbgUartPkg.sv
package dbgUartPkg;

  typedef enum logic [2:0] {
    AB_IDLE,
    AB_ARM,
    AB_MEAS,
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  typedef enum logic {
    TX_IDLE,
    TX_BUSY
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic measClr;
    logic measInc;
    logic lockPeriod;
    logic rxLoadHalf;
    logic rxLoadFull;
    logic rxShift;
    logic rxDeliver;
    logic txLoad;
    logic txShift;
  } dpStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic rxLine;
    logic rxFall;
    logic rxTick;
    logic rxBitLast;
    logic measOk;
    logic breakSeen;
    logic txTick;
    logic txBitLast;
  } dpStatus_t;

endpackage

// File: rtl/dbgUartDatapath.sv
module dbgUartDatapath
  import dbgUartPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPin,
  input  logic       rxReady,
  input  logic [7:0] txData,
  input  dpStrobe_t  strobe,
  output dpStatus_t  status,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       txLine
);

  localparam int MEAS_W = CNT_W + 3;
  localparam int LOW_W  = CNT_W + 4;
  localparam int FRAME_BITS = 10;
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

  // input synchronizer, reset to the idle level
  logic [SYNC_STAGES-1:0] syncQ;
  logic rxLine, rxPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '1;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxPin};
      rxPrev <= rxLine;
    end
  end
  assign rxLine = syncQ[SYNC_STAGES-1];

  // rate measurement
  logic [MEAS_W-1:0] measCnt;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  measPeriod;
  assign measPeriod = measCnt[MEAS_W-1:3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      measCnt <= '0;
      period  <= '0;
    end else begin
      if (strobe.measClr)                 measCnt <= '0;
      else if (strobe.measInc && !(&measCnt)) measCnt <= measCnt + 1'b1;
      if (strobe.lockPeriod)              period  <= measPeriod;
    end
  end

  // receive timing and shift
  logic [CNT_W-1:0] rxTimer;
  logic [2:0]       bitIdx;
  logic [7:0]       rxShreg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxTimer <= '0;
      bitIdx  <= '0;
      rxShreg <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strobe.rxLoadHalf)      rxTimer <= (period >> 1) - 1'b1;
      else if (strobe.rxLoadFull) rxTimer <= period - 1'b1;
      else if (rxTimer != '0)     rxTimer <= rxTimer - 1'b1;

      if (strobe.rxLoadHalf)   bitIdx <= '0;
      else if (strobe.rxShift) bitIdx <= bitIdx + 1'b1;

      if (strobe.rxShift) rxShreg <= {rxLine, rxShreg[7:1]};

      if (strobe.rxDeliver) begin
        rxData  <= rxShreg;
        rxValid <= 1'b1;
      end else if (rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  // break detection: low time against ten bit periods
  logic [LOW_W-1:0] lowCnt;
  logic [LOW_W-1:0] brkLimit;
  assign brkLimit = ({4'b0, period} << 3) + ({4'b0, period} << 1);

  always_ff @(posedge clk) begin
    if (!rstN)             lowCnt <= '0;
    else if (rxLine)       lowCnt <= '0;
    else if (!(&lowCnt))   lowCnt <= lowCnt + 1'b1;
  end

  // transmit
  logic [CNT_W-1:0]      txTimer;
  logic [3:0]            txCnt;
  logic [FRAME_BITS-1:0] txShreg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txTimer <= '0;
      txCnt   <= '0;
      txShreg <= '1;
    end else if (strobe.txLoad) begin
      txTimer <= period - 1'b1;
      txCnt   <= '0;
      txShreg <= {1'b1, txData, 1'b0};
    end else if (strobe.txShift) begin
      txTimer <= period - 1'b1;
      txCnt   <= txCnt + 1'b1;
      txShreg <= {1'b1, txShreg[FRAME_BITS-1:1]};
    end else if (txTimer != '0) begin
      txTimer <= txTimer - 1'b1;
    end
  end
  assign txLine = txShreg[0];

  always_comb begin
    status.rxLine    = rxLine;
    status.rxFall    = rxPrev & ~rxLine;
    status.rxTick    = (rxTimer == '0);
    status.rxBitLast = (bitIdx == 3'd7);
    status.measOk    = (measPeriod >= MIN_P);
    status.breakSeen = (lowCnt > brkLimit);
    status.txTick    = (txTimer == '0);
    status.txBitLast = (txCnt == 4'(FRAME_BITS - 1));
  end

endmodule

// File: rtl/dbgUartControl.sv
module dbgUartControl
  import dbgUartPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStatus_t status,
  input  logic      txValid,
  output dpStrobe_t strobe,
  output logic      txReady,
  output logic      frameErr,
  output logic      baudLocked
);

  rxState_t rxState, rxNext;
  txState_t txState, txNext;
  logic     ferrNext;

  assign baudLocked = !(rxState inside {AB_IDLE, AB_ARM, AB_MEAS});
  assign txReady    = baudLocked && (txState == TX_IDLE);

  always_comb begin
    strobe   = '0;
    rxNext   = rxState;
    ferrNext = 1'b0;
    if (baudLocked && status.breakSeen) begin
      rxNext = AB_IDLE;
    end else begin
      unique case (rxState)
        AB_IDLE: if (status.rxLine) begin
          strobe.measClr = 1'b1;
          rxNext = AB_ARM;
        end
        AB_ARM: if (!status.rxLine) begin
          strobe.measInc = 1'b1;
          rxNext = AB_MEAS;
        end
        AB_MEAS: begin
          if (!status.rxLine) begin
            strobe.measInc = 1'b1;
          end else if (status.measOk) begin
            strobe.lockPeriod = 1'b1;
            rxNext = RX_IDLE;
          end else begin
            strobe.measClr = 1'b1;
            rxNext = AB_ARM;
          end
        end
        RX_IDLE: if (status.rxFall) begin
          strobe.rxLoadHalf = 1'b1;
          rxNext = RX_START;
        end
        RX_START: if (status.rxTick) begin
          if (!status.rxLine) begin
            strobe.rxLoadFull = 1'b1;
            rxNext = RX_DATA;
          end else begin
            rxNext = RX_IDLE;
          end
        end
        RX_DATA: if (status.rxTick) begin
          strobe.rxShift    = 1'b1;
          strobe.rxLoadFull = 1'b1;
          if (status.rxBitLast) rxNext = RX_STOP;
        end
        RX_STOP: if (status.rxTick) begin
          if (status.rxLine) strobe.rxDeliver = 1'b1;
          else               ferrNext = 1'b1;
          rxNext = RX_IDLE;
        end
        default: rxNext = AB_IDLE;
      endcase
    end

    txNext = txState;
    unique case (txState)
      TX_IDLE: if (txValid && baudLocked) begin
        strobe.txLoad = 1'b1;
        txNext = TX_BUSY;
      end
      TX_BUSY: if (status.txTick) begin
        strobe.txShift = 1'b1;
        if (status.txBitLast) txNext = TX_IDLE;
      end
      default: txNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState  <= AB_IDLE;
      txState  <= TX_IDLE;
      frameErr <= 1'b0;
    end else begin
      rxState  <= rxNext;
      txState  <= txNext;
      frameErr <= ferrNext;
    end
  end

endmodule

// File: rtl/dbgUart.sv
module dbgUart
  import dbgUartPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPin,
  output logic       txLine,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic       frameErr,
  output logic       baudLocked
);

  dpStrobe_t strobe;
  dpStatus_t status;

  dbgUartDatapath #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .MIN_PERIOD(MIN_PERIOD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxPin(rxPin), .rxReady(rxReady),
    .txData(txData), .strobe(strobe), .status(status),
    .rxData(rxData), .rxValid(rxValid), .txLine(txLine)
  );

  dbgUartControl u_ctl (
    .clk(clk), .rstN(rstN), .status(status), .txValid(txValid),
    .strobe(strobe), .txReady(txReady), .frameErr(frameErr),
    .baudLocked(baudLocked)
  );

endmodule

// File: rtl/dbgUartChk.sv
module dbgUartChk (
  input logic       clk,
  input logic       rstN,
  input logic       txLine,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       rxReady,
  input logic       txValid,
  input logic       txReady,
  input logic       frameErr,
  input logic       baudLocked
);

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (txLine && !rxValid && !txReady && !frameErr && !baudLocked)); // R1

  AST_NO_RX_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(baudLocked)); // R2

  AST_NO_TX_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> baudLocked); // R2

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData))); // R5

  AST_FERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr); // R6

  AST_TX_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady); // R8

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine); // R8

endmodule

bind dbgUart dbgUartChk u_chk (
  .clk(clk), .rstN(rstN), .txLine(txLine), .rxData(rxData),
  .rxValid(rxValid), .rxReady(rxReady), .txValid(txValid),
  .txReady(txReady), .frameErr(frameErr), .baudLocked(baudLocked)
);

// File: tb/dbgUart_tb.sv
module dbgUart_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxPin = 1'b1;
  logic       rxReady = 1'b1;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txLine, rxValid, txReady, frameErr, baudLocked;
  logic [7:0] rxData;

  dbgUart u_dut (
    .clk(clk), .rstN(rstN), .rxPin(rxPin), .txLine(txLine),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .frameErr(frameErr), .baudLocked(baudLocked)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, capCnt = 0, ferrCnt = 0;
  logic [7:0] capData = '0;
  bit finished = 0;

  // data byte and stop bit level; a byte is expected only with a high stop bit
  localparam logic [8:0] VEC [0:5] = '{
    {8'hA5, 1'b1}, {8'h00, 1'b1}, {8'hFF, 1'b1},
    {8'h3C, 1'b0}, {8'h81, 1'b1}, {8'h7E, 1'b1}
  };

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid && rxReady) begin capCnt++; capData = rxData; end
      if (frameErr) ferrCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic sendByte(input logic [7:0] d, input logic stopBit, input int bc);
    rxPin = 1'b0; waitCyc(bc);
    for (int i = 0; i < 8; i++) begin rxPin = d[i]; waitCyc(bc); end
    rxPin = stopBit; waitCyc(bc);
    rxPin = 1'b1; waitCyc(2 * bc);
  endtask

  task automatic txCheck(input logic [7:0] d, input int bc, input string req);
    logic [9:0] got;
    chk(txReady == 1'b1, req, "txReady before send", txReady, 1);
    txData = d; txValid = 1'b1;
    @(posedge clk); #2;
    txValid = 1'b0;
    chk(txReady == 1'b0, "R8", "txReady during frame", txReady, 0);
    repeat (bc / 2) @(posedge clk);
    #2;
    for (int i = 0; i < 10; i++) begin
      got[i] = txLine;
      if (i < 9) begin repeat (bc) @(posedge clk); #2; end
    end
    chk(got == {1'b1, d, 1'b0}, req, "tx frame bits", got, {1'b1, d, 1'b0});
    waitCyc(bc);
    chk(txReady == 1'b1 && txLine == 1'b1, "R8", "idle after frame",
        {txReady, txLine}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int prevCap, prevErr;
    waitCyc(5);
    // R1: reset state
    chk(txLine && !rxValid && !txReady && !frameErr && !baudLocked, "R1",
        "reset outputs", {txLine, rxValid, txReady, frameErr, baudLocked}, 5'b10000);
    rstN = 1'b1;
    waitCyc(5);

    // R2, R3: 0x55 low runs are one bit (16 clocks) -> period 2 < 4, rejected
    sendByte(8'h55, 1'b1, 16);
    chk(!baudLocked, "R3", "short low run keeps unlocked", baudLocked, 0);
    chk(capCnt == 0 && !rxValid, "R2", "no byte before lock", capCnt, 0);
    chk(!txReady, "R2", "txReady low before lock", txReady, 0);

    // R4: sync at 16 clocks per bit
    sendByte(8'h80, 1'b1, 16);
    chk(baudLocked, "R4", "locked after sync", baudLocked, 1);
    chk(capCnt == 0, "R4", "sync not delivered", capCnt, 0);

    // R5, R6: table of frames
    for (int v = 0; v < 6; v++) begin
      prevCap = capCnt; prevErr = ferrCnt;
      sendByte(VEC[v][8:1], VEC[v][0], 16);
      if (VEC[v][0]) begin
        chk(capCnt == prevCap + 1 && capData == VEC[v][8:1], "R5", "rx byte",
            capData, VEC[v][8:1]);
        chk(ferrCnt == prevErr, "R6", "no frame error on good stop", ferrCnt, prevErr);
      end else begin
        chk(capCnt == prevCap, "R6", "bad stop delivers nothing", capCnt, prevCap);
        chk(ferrCnt == prevErr + 1, "R6", "single frameErr pulse", ferrCnt, prevErr + 1);
      end
    end

    // R5: hold while not ready
    rxReady = 1'b0;
    prevCap = capCnt;
    sendByte(8'h5A, 1'b1, 16);
    chk(rxValid && rxData == 8'h5A, "R5", "byte pending", rxData, 8'h5A);
    waitCyc(20);
    chk(rxValid && rxData == 8'h5A && capCnt == prevCap, "R5", "byte held",
        rxData, 8'h5A);
    rxReady = 1'b1;
    waitCyc(2);
    chk(capCnt == prevCap + 1 && !rxValid, "R5", "byte taken once", capCnt, prevCap + 1);

    // R9: short glitch
    prevCap = capCnt; prevErr = ferrCnt;
    rxPin = 1'b0; waitCyc(3); rxPin = 1'b1; waitCyc(40);
    chk(capCnt == prevCap && ferrCnt == prevErr, "R9", "glitch ignored",
        capCnt, prevCap);
    sendByte(8'hC6, 1'b1, 16);
    chk(capData == 8'hC6, "R9", "receive after glitch", capData, 8'hC6);

    // R8, R4: transmit at 16 clocks per bit
    txCheck(8'hC3, 16, "R4");
    txCheck(8'h1E, 16, "R8");

    // R7: break then relock at 24 clocks per bit
    rxPin = 1'b0; waitCyc(200); rxPin = 1'b1; waitCyc(10);
    chk(!baudLocked && !txReady, "R7", "break unlocks", baudLocked, 0);
    sendByte(8'h80, 1'b1, 24);
    chk(baudLocked, "R7", "relock after break", baudLocked, 1);
    prevCap = capCnt;
    sendByte(8'h96, 1'b1, 24);
    chk(capCnt == prevCap + 1 && capData == 8'h96, "R7", "rx at new rate",
        capData, 8'h96);
    txCheck(8'h3A, 24, "R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule